// File: doc/BRIEF.md
# Dual-Frame Serial Converter Read Controller

This block sits on the host side of a three-wire link to a 14-bit sampling converter. It drives an active-low chip select (`cs_n`) and a serial clock (`sclk`), captures the serial data line (`sdo`), and returns one result word per frame. The converter takes a sample when chip select falls. It shifts bits out on falling clock edges, so the host captures them on its own rising edges.

Two frame kinds are supported, and each request picks one. In the short kind (16 clock pulses) the converter pipelines: the word read during a frame belongs to the sample taken in the frame before. In the long kind (32 clock pulses) the converter digitises the sample taken at this frame's chip-select fall and sends it late in the same frame. The converter learns which kind applies only from when chip select returns high, so the controller keeps chip select low for exactly 16 or 32 pulses.

Each result comes out with a one-cycle valid pulse, the data word, a tag naming the sample it belongs to, and a stale flag for pipelined words that cannot be trusted.

Top module: `adc_frame_host`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `res_valid` is 0.
- R2: When `start` is 1 while no frame is active and the inter-frame gap has elapsed, `cs_n` falls on the next clock. `busy` is 1 exactly while `cs_n` is 0. A `start` seen during a frame is ignored and produces no extra frame or result.
- R3: Each `sclk` high phase and low phase lasts max(`half_div`,2) system clocks. `sclk` is 0 whenever `cs_n` is 1.
- R4: With `mode_long`=0 latched (short frame), exactly 16 `sclk` pulses are issued. The word is built MSB first from `sdo` sampled at rising edges 1 to 14, with edge 1 giving bit 13.
- R5: With `mode_long`=1 latched (long frame), exactly 32 `sclk` pulses are issued. The word is built MSB first from `sdo` sampled at rising edges 19 to 32, with edge 19 giving bit 13.
- R6: Each frame produces exactly one `res_valid` pulse, one system clock wide. It occurs while `cs_n` is 0, at the rising edge that carries bit 0.
- R7: Frames are numbered from 1 after reset, and the number increases by one at each `cs_n` fall (modulo 2^`TAG_W`). A long frame's `res_tag` is its own number. A short frame's `res_tag` is the previous frame's number (0 for the first frame after reset).
- R8: `res_stale` is 1 for a short-frame result whose preceding frame was long, or that has no preceding frame since reset. It is 0 for every other short-frame result and for every long-frame result.
- R9: `mode_long` is sampled only in the clock where a frame starts. Changing it during a frame does not alter that frame's length, data window, tag or stale flag.
- R10: After the last falling `sclk` edge, `cs_n` stays low with `sclk` low for one half period before it rises. Between frames, `cs_n` then stays high for at least max(`gap_min`,1) system clocks.
- R11: `sdo` has no effect outside the selected 14-edge data window, including while `cs_n` is high and on the unused edges of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request, accepted only when idle |
| mode_long | input | 1 | 0 = 16-pulse pipelined frame, 1 = 32-pulse frame |
| half_div | input | DIV_W | Serial clock half period in system clocks (values below 2 act as 2) |
| gap_min | input | GAP_W | Minimum chip-select high time in system clocks (0 acts as 1) |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| busy | output | 1 | High while a frame is active |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Result word |
| res_tag | output | TAG_W | Number of the frame whose sample the word holds |
| res_stale | output | 1 | Result of a short frame that cannot be trusted |

## Verification
The converter model drives real bits only in the window a correct host reads. Everywhere else it drives a changing garbage pattern. A host that reads the wrong edges, drops the first bit, or mixes up the two windows therefore returns corrupted words. Mixed sequences of short and long frames cover the tag lag and the stale rule: short after reset, short after long, and long after short. An off-by-one tag or a missing stale flag shows up as a scoreboard mismatch. Mid-frame flips of `mode_long` and mid-frame `start` pulses check that the latched mode holds, because a design that resampled them would stretch or cut the frame or emit extra results. A long run of short frames at the minimum divider and gap wraps the tag counter and checks the clamping of the divider and gap values.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    localparam int SHORT_CLKS = 16;
    localparam int LONG_CLKS  = 32;
    localparam int EDGE_W     = $clog2(LONG_CLKS + 1);

    typedef enum logic {
        FRM_SHORT = 1'b0,
        FRM_LONG  = 1'b1
    } frame_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOW,
        SQ_HIGH,
        SQ_TAIL,
        SQ_GAP
    } seq_state_e;

    typedef struct packed {
        logic              fire;
        logic [EDGE_W-1:0] idx;
    } sclk_rise_t;

    function automatic logic [EDGE_W-1:0] frame_pulses(frame_kind_e k);
        return (k == FRM_LONG) ? EDGE_W'(LONG_CLKS) : EDGE_W'(SHORT_CLKS);
    endfunction

endpackage

// File: rtl/adcf_seq.sv
module adcf_seq
    import adcf_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_long,
    input  logic [DIV_W-1:0] half_div,
    input  logic [GAP_W-1:0] gap_min,
    output logic             cs_n,
    output logic             sclk,
    output frame_kind_e      kind,
    output logic             frame_start,
    output sclk_rise_t       rise
);

    seq_state_e        st;
    logic [DIV_W-1:0]  tmr;
    logic [GAP_W-1:0]  gtmr;
    logic [EDGE_W-1:0] rise_cnt;
    logic              csn_q;
    logic              sclk_q;
    frame_kind_e       kind_q;
    logic [DIV_W-1:0]  h_eff;
    logic [GAP_W-1:0]  g_eff;

    assign h_eff = (half_div < DIV_W'(2)) ? DIV_W'(2) : half_div;
    assign g_eff = (gap_min == '0) ? GAP_W'(1) : gap_min;

    assign frame_start = (st == SQ_IDLE) && start;
    assign rise.fire   = (st == SQ_LOW) && (tmr == '0);
    assign rise.idx    = rise_cnt + EDGE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            tmr      <= '0;
            gtmr     <= '0;
            rise_cnt <= '0;
            csn_q    <= 1'b1;
            sclk_q   <= 1'b0;
            kind_q   <= FRM_SHORT;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        csn_q    <= 1'b0;
                        kind_q   <= frame_kind_e'(mode_long);
                        rise_cnt <= '0;
                        tmr      <= h_eff - DIV_W'(1);
                        st       <= SQ_LOW;
                    end
                end
                SQ_LOW: begin
                    if (tmr == '0) begin
                        sclk_q   <= 1'b1;
                        rise_cnt <= rise_cnt + EDGE_W'(1);
                        tmr      <= h_eff - DIV_W'(1);
                        st       <= SQ_HIGH;
                    end else begin
                        tmr <= tmr - DIV_W'(1);
                    end
                end
                SQ_HIGH: begin
                    if (tmr == '0) begin
                        sclk_q <= 1'b0;
                        tmr    <= h_eff - DIV_W'(1);
                        st     <= (rise_cnt == frame_pulses(kind_q)) ? SQ_TAIL : SQ_LOW;
                    end else begin
                        tmr <= tmr - DIV_W'(1);
                    end
                end
                SQ_TAIL: begin
                    if (tmr == '0) begin
                        csn_q <= 1'b1;
                        gtmr  <= g_eff - GAP_W'(1);
                        st    <= SQ_GAP;
                    end else begin
                        tmr <= tmr - DIV_W'(1);
                    end
                end
                SQ_GAP: begin
                    if (gtmr == '0) begin
                        st <= SQ_IDLE;
                    end else begin
                        gtmr <= gtmr - GAP_W'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign cs_n = csn_q;
    assign sclk = sclk_q;
    assign kind = kind_q;

endmodule

// File: rtl/adcf_capture.sv
module adcf_capture
    import adcf_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdo,
    input  frame_kind_e       kind,
    input  sclk_rise_t        rise,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    localparam logic [EDGE_W-1:0] SHORT_FIRST = EDGE_W'(1);
    localparam logic [EDGE_W-1:0] SHORT_LAST  = EDGE_W'(DATA_W);
    localparam logic [EDGE_W-1:0] LONG_LAST   = EDGE_W'(LONG_CLKS);
    localparam logic [EDGE_W-1:0] LONG_FIRST  = EDGE_W'(LONG_CLKS - DATA_W + 1);

    logic              sdo_q;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] sh_next;
    logic              in_win;
    logic              last_bit;

    assign sh_next = {sh[DATA_W-2:0], sdo_q};

    always_comb begin
        if (kind == FRM_LONG) begin
            in_win   = (rise.idx >= LONG_FIRST) && (rise.idx <= LONG_LAST);
            last_bit = (rise.idx == LONG_LAST);
        end else begin
            in_win   = (rise.idx >= SHORT_FIRST) && (rise.idx <= SHORT_LAST);
            last_bit = (rise.idx == SHORT_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b0;
            sh    <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            sdo_q <= sdo;
            valid <= 1'b0;
            if (rise.fire && in_win) begin
                sh <= sh_next;
                if (last_bit) begin
                    data  <= sh_next;
                    valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adcf_tagger.sv
module adcf_tagger
    import adcf_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  frame_kind_e      kind_in,
    output logic [TAG_W-1:0] tag,
    output logic             stale
);

    logic [TAG_W-1:0] id_q;
    logic             last_short_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q         <= '0;
            last_short_q <= 1'b0;
            tag          <= '0;
            stale        <= 1'b0;
        end else if (frame_start) begin
            id_q         <= id_q + TAG_W'(1);
            last_short_q <= (kind_in == FRM_SHORT);
            if (kind_in == FRM_LONG) begin
                tag   <= id_q + TAG_W'(1);
                stale <= 1'b0;
            end else begin
                tag   <= id_q;
                stale <= !last_short_q;
            end
        end
    end

endmodule

// File: rtl/adc_frame_host.sv
module adc_frame_host
    import adcf_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int TAG_W  = 8,
    parameter int DIV_W  = 8,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode_long,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [GAP_W-1:0]  gap_min,
    input  logic              sdo,
    output logic              cs_n,
    output logic              sclk,
    output logic              busy,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [TAG_W-1:0]  res_tag,
    output logic              res_stale
);

    frame_kind_e kind;
    logic        frame_start;
    sclk_rise_t  rise;

    adcf_seq #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .mode_long   (mode_long),
        .half_div    (half_div),
        .gap_min     (gap_min),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .kind        (kind),
        .frame_start (frame_start),
        .rise        (rise)
    );

    adcf_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .sdo   (sdo),
        .kind  (kind),
        .rise  (rise),
        .valid (res_valid),
        .data  (res_data)
    );

    adcf_tagger #(.TAG_W(TAG_W)) u_tag (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .kind_in     (frame_kind_e'(mode_long)),
        .tag         (res_tag),
        .stale       (res_stale)
    );

    assign busy = !cs_n;

endmodule

// File: rtl/adcf_host_chk.sv
module adcf_host_chk #(
    parameter int GAP_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_long,
    input logic [GAP_W-1:0] gap_min,
    input logic             cs_n,
    input logic             sclk,
    input logic             res_valid,
    input logic             res_stale
);

    logic             csn_d;
    logic             sclk_d;
    logic             mode_d;
    logic             frame_long;
    logic [5:0]       rcnt;
    logic [15:0]      hi_cnt;
    logic [GAP_W-1:0] g_eff;

    assign g_eff = (gap_min == '0) ? GAP_W'(1) : gap_min;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d      <= 1'b1;
            sclk_d     <= 1'b0;
            mode_d     <= 1'b0;
            frame_long <= 1'b0;
            rcnt       <= '0;
            hi_cnt     <= '1;
        end else begin
            csn_d  <= cs_n;
            sclk_d <= sclk;
            mode_d <= mode_long;
            if (csn_d && !cs_n) begin
                frame_long <= mode_d;
                rcnt       <= '0;
            end else if (sclk && !sclk_d && rcnt != '1) begin
                rcnt <= rcnt + 6'd1;
            end
            if (cs_n) begin
                if (hi_cnt != '1) hi_cnt <= hi_cnt + 16'd1;
            end else begin
                hi_cnt <= '0;
            end
        end
    end

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid); // R6
    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst) res_valid |-> !cs_n); // R6
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> (rcnt == (frame_long ? 6'd32 : 6'd16))); // R4 R5 R9
    AST_LONG_FRESH: assert property (@(posedge clk) disable iff (rst) (res_valid && frame_long) |-> !res_stale); // R8
    AST_CS_GAP: assert property (@(posedge clk) disable iff (rst) (csn_d && !cs_n) |-> (hi_cnt >= 16'(g_eff))); // R10
    AST_CS_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> $past(!sclk)); // R10

endmodule

bind adc_frame_host adcf_host_chk #(.GAP_W(GAP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_long (mode_long),
    .gap_min   (gap_min),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .res_valid (res_valid),
    .res_stale (res_stale)
);

// File: tb/tb_adc_frame_host.sv
module tb_adc_frame_host;

    localparam int DW   = 14;
    localparam int TW   = 8;
    localparam int DIVW = 8;
    localparam int GW   = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            mode_long = 1'b0;
    logic [DIVW-1:0] half_div = 8'd3;
    logic [GW-1:0]   gap_min = 8'd4;
    logic            sdo = 1'b0;
    logic            cs_n, sclk, busy, res_valid, res_stale;
    logic [DW-1:0]   res_data;
    logic [TW-1:0]   res_tag;

    adc_frame_host #(.DATA_W(DW), .TAG_W(TW), .DIV_W(DIVW), .GAP_W(GW)) dut (
        .clk(clk), .rst(rst), .start(start), .mode_long(mode_long),
        .half_div(half_div), .gap_min(gap_min), .sdo(sdo),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .res_valid(res_valid),
        .res_data(res_data), .res_tag(res_tag), .res_stale(res_stale)
    );

    typedef struct packed {
        logic [DW-1:0] d;
        logic [TW-1:0] t;
        logic          s;
        logic          lng;
    } exp_t;

    exp_t q[$];

    int drv_chk = 0, drv_fail = 0;
    int mon_chk = 0, mon_fail = 0;
    int h_exp = 3, g_exp = 4;

    function automatic logic [DW-1:0] samp(input logic [TW-1:0] id);
        if (id == 8'd3) return 14'h3FFF;
        if (id == 8'd4) return 14'h0000;
        return DW'(int'(id) * 9157) ^ 14'h12A5;
    endfunction

    // converter model: MSB at chip-select fall, later bits on falling sclk
    logic [TW-1:0] m_fid = '0;
    int            m_rc = 0;
    logic          m_csn_p = 1'b1, m_sclk_p = 1'b0;

    function automatic logic mbit(input int k, input logic [TW-1:0] fid);
        logic [DW-1:0] pv, cv;
        pv = samp(fid - 8'd1);
        cv = samp(fid);
        if (k >= 1 && k <= 14) return pv[14-k];
        if (k >= 19 && k <= 32) return cv[32-k];
        return logic'(k[0] ^ k[2] ^ 1'b1);  // garbage on unused edges (R11)
    endfunction

    always @(negedge clk) begin
        if (m_csn_p && !cs_n) begin
            m_fid = m_fid + 8'd1;
            m_rc  = 0;
            sdo   = mbit(1, m_fid);
        end else if (!cs_n && sclk && !m_sclk_p) begin
            m_rc = m_rc + 1;
        end else if (!cs_n && !sclk && m_sclk_p) begin
            sdo = mbit(m_rc + 1, m_fid);
        end else if (cs_n) begin
            sdo = ~sdo;  // line undriven: toggling junk (R11)
        end
        m_csn_p  = cs_n;
        m_sclk_p = sclk;
    end

    // monitor: scoreboard and gap measurement
    int hi_run = 1000;
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                if (q.size() == 0) begin
                    mon_chk++; mon_fail++;
                    $display("FAIL R2 unexpected result data=%h tag=%0d exp=none", res_data, res_tag);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    mon_chk++;
                    if (res_data !== e.d) begin
                        mon_fail++;
                        $display("FAIL %s data act=%h exp=%h", e.lng ? "R5" : "R4", res_data, e.d);
                    end
                    mon_chk++;
                    if (res_tag !== e.t) begin
                        mon_fail++;
                        $display("FAIL R7 tag act=%0d exp=%0d", res_tag, e.t);
                    end
                    mon_chk++;
                    if (res_stale !== e.s) begin
                        mon_fail++;
                        $display("FAIL R8 stale act=%0b exp=%0b", res_stale, e.s);
                    end
                end
            end
            if (cs_n) begin
                hi_run++;
            end else begin
                if (hi_run > 0 && hi_run < 1000) begin
                    mon_chk++;
                    if (hi_run < g_exp) begin
                        mon_fail++;
                        $display("FAIL R10 cs high run act=%0d exp>=%0d", hi_run, g_exp);
                    end
                end
                hi_run = 0;
            end
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog act=%0d cycles exp=<150000", cyc);
            $display("%0d/%0d checks passed", drv_chk + mon_chk + 1 - drv_fail - mon_fail - 1,
                     drv_chk + mon_chk + 1);
            $finish;
        end
    end

    logic [TW-1:0] drv_id = '0;
    logic          prev_short = 1'b0;

    task automatic chk(input logic ok, input string msg, input int act, input int exp_v);
        drv_chk++;
        if (!ok) begin
            drv_fail++;
            $display("FAIL %s act=%0d exp=%0d", msg, act, exp_v);
        end
    endtask

    task automatic run_frame(input logic lng, input bit disturb);
        exp_t e;
        int   rises, run, hmin, hmax;
        logic ps;
        drv_id = drv_id + 8'd1;
        e.lng = lng;
        e.d   = lng ? samp(drv_id) : samp(drv_id - 8'd1);
        e.t   = lng ? drv_id : drv_id - 8'd1;
        e.s   = lng ? 1'b0 : !prev_short;
        prev_short = !lng;
        q.push_back(e);
        mode_long = lng;
        start = 1'b1;
        do @(negedge clk); while (!busy);
        start = 1'b0;
        rises = 0; run = 0; hmin = 1000; hmax = 0; ps = 1'b0;
        while (busy) begin
            @(negedge clk);
            if (sclk) run++;
            if (sclk && !ps) rises++;
            if (!sclk && ps) begin
                if (run < hmin) hmin = run;
                if (run > hmax) hmax = run;
                run = 0;
            end
            ps = sclk;
            if (disturb) begin
                mode_long = (rises >= 3) ? !lng : lng;   // R9 mid-frame flip
                start     = (rises == 4) && sclk;        // R2 mid-frame request
            end
        end
        start = 1'b0;
        chk(rises == (lng ? 32 : 16), lng ? "R5 pulse count" : "R4 pulse count", rises, lng ? 32 : 16);
        chk(hmin == h_exp && hmax == h_exp, "R3 high phase length", hmax, h_exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n === 1'b1, "R1 cs_n after reset", int'(cs_n), 1);
        chk(sclk === 1'b0, "R1 sclk after reset", int'(sclk), 0);
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(res_valid === 1'b0, "R1 valid after reset", int'(res_valid), 0);
        repeat (5) @(negedge clk);
        chk(cs_n === 1'b1, "R2 no frame without start", int'(cs_n), 1);

        run_frame(1'b0, 1'b0);  // first short: stale, tag 0
        run_frame(1'b0, 1'b0);
        run_frame(1'b0, 1'b1);
        run_frame(1'b1, 1'b0);  // samples 3FFF and 0
        run_frame(1'b1, 1'b1);
        run_frame(1'b0, 1'b0);  // short after long: stale
        run_frame(1'b1, 1'b0);
        run_frame(1'b0, 1'b0);

        half_div = 8'd0; gap_min = 8'd0; h_exp = 2; g_exp = 1;
        run_frame(1'b0, 1'b0);
        run_frame(1'b1, 1'b0);
        run_frame(1'b0, 1'b1);
        for (int i = 0; i < 250; i++) run_frame(1'b0, 1'b0);  // tag wrap (R7)
        run_frame(1'b1, 1'b0);

        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R6 one result per frame", q.size(), 0);
        chk(cs_n === 1'b1 && busy === 1'b0, "R2 idle after last frame", int'(busy), 0);

        $display("%0d/%0d checks passed", drv_chk + mon_chk - drv_fail - mon_fail, drv_chk + mon_chk);
        $finish;
    end

endmodule